// File: doc/BRIEF.md
# Data Watchpoint Comparator

This block watches the load/store stream of a processor pipeline. Each access is compared against two programmable watch addresses and, if set up to do so, against two watch data values. The result appears in the same cycle as the access strobe, so the pipeline can hold the instruction back before it executes. The two watch addresses serve either as two independent exact-match points or together as the bounds of a single window. The window can be inclusive, with the low bound counting as inside, or exclusive, covering everything outside the window.

Data qualification narrows a hit to accesses that carry a particular value. Each data register has a byte-lane mask. Only lanes that are both selected by the mask and actually touched by the access (a byte, a half-word or the whole word) are compared. Software sets everything up through a small register write port. How the resulting event is delivered is outside this block.

Top module: `data_watch_unit`

## Requirements
- R1: After reset, all watch registers and control fields are zero. No access of any type raises any output.
- R2: In exact mode (control mode field bits [5:4] = 00 or 11), addr_hit[0] is set when a permitted access has an address equal to watch address A. addr_hit[1] is set likewise for watch address B.
- R3: Control bits gate the access types: bit 0 allows reads on comparator A, bit 1 allows writes on A, bit 2 allows reads on B, bit 3 allows writes on B. A type that is not allowed never hits.
- R4: In inclusive window mode (mode 01), addr_hit[0] is set when A ≤ address < B, using A's type enables. addr_hit[1] stays 0 in any window mode.
- R5: In exclusive window mode (mode 10), addr_hit[0] is set when address < A or address ≥ B, using A's type enables.
- R6: value_hit[i] is set only when the matching address hit is present (addr_hit[i] in exact mode, addr_hit[0] in window mode) and the compared lanes equal the same lanes of data register A (i=0) or B (i=1). Lane n is data bits [8n+7:8n].
- R7: Lanes accessed: size 0 (byte) is lane address[1:0]; size 1 (half-word) is lanes {address[1],0} and {address[1],1}; size 2 (word) is all four lanes. Only lanes that are both accessed and masked are compared. If no lane is both, there is no value hit.
- R8: A zero lane mask turns data qualification off. In exact mode, watch_event = OR over i of addr_hit[i] & (mask_i == 0 | value_hit[i]).
- R9: In window mode, watch_event = addr_hit[0] & (both masks zero | value_hit[0] | value_hit[1]). Either data register can qualify.
- R10: All outputs follow the access inputs in the same cycle. With acc_valid low, every output is 0.
- R11: A register write takes effect from the clock edge at which cfg_we is sampled high. Select 0 is watch address A, 1 is watch address B, 2 is data register A, 3 is data register B, and 4 is control. Control holds the enables [3:0], the mode [5:4], mask A [11:8] and mask B [15:12]. Other selects change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word |
| acc_addr | input | 32 | Access byte address |
| acc_data | input | 32 | Access data in lane position |
| addr_hit | output | 2 | Address hit, comparator A in bit 0 |
| value_hit | output | 2 | Data-qualified hit, register A in bit 0 |
| watch_event | output | 1 | Combined watch event |

## Verification
The bench tests the window bounds on both sides. It checks that the low bound is inside and the high bound outside in inclusive mode, and the reverse in exclusive mode. An off-by-one comparison fails these tests at exactly one address. It tests read/write gating with an access of the disallowed type, which a design that ignores the type would report as a hit. It runs sub-word accesses against masks that cover only some lanes: one case hits on a masked lane while other lanes differ, and another touches no masked lane. A design that compares all masked lanes, or treats an empty overlap as a match, gets these wrong. Window-mode accesses matching only data register B show whether either register can qualify the event.

// File: rtl/watch_pkg.sv
package watch_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT  = 2'b00,
    MODE_INSIDE = 2'b01,
    MODE_OUTSIDE = 2'b10,
    MODE_EXACT2 = 2'b11
  } watch_mode_e;

  localparam int SEL_ADDR_A = 0;
  localparam int SEL_ADDR_B = 1;
  localparam int SEL_VAL_A  = 2;
  localparam int SEL_VAL_B  = 3;
  localparam int SEL_CTRL   = 4;

  localparam int CTRL_EN_LSB   = 0;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CTRL_MASK_LSB = 8;
endpackage

// File: rtl/watch_cfg_regs.sv
module watch_cfg_regs
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int CFG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b,
  output logic [3:0]        type_en,
  output watch_mode_e       mode,
  output logic [LANES-1:0]  mask_a,
  output logic [LANES-1:0]  mask_b
);
  logic [ADDR_W-1:0] addr_a_d, addr_b_d;
  logic [DATA_W-1:0] val_a_d, val_b_d;
  logic [3:0]        type_en_d;
  watch_mode_e       mode_d;
  logic [LANES-1:0]  mask_a_d, mask_b_d;

  always_comb begin
    addr_a_d  = addr_a;
    addr_b_d  = addr_b;
    val_a_d   = val_a;
    val_b_d   = val_b;
    type_en_d = type_en;
    mode_d    = mode;
    mask_a_d  = mask_a;
    mask_b_d  = mask_b;
    if (cfg_we) begin
      case (int'(cfg_sel))
        SEL_ADDR_A: addr_a_d = cfg_wdata[ADDR_W-1:0];
        SEL_ADDR_B: addr_b_d = cfg_wdata[ADDR_W-1:0];
        SEL_VAL_A:  val_a_d  = cfg_wdata[DATA_W-1:0];
        SEL_VAL_B:  val_b_d  = cfg_wdata[DATA_W-1:0];
        SEL_CTRL: begin
          type_en_d = cfg_wdata[CTRL_EN_LSB +: 4];
          mode_d    = watch_mode_e'(cfg_wdata[CTRL_MODE_LSB +: 2]);
          mask_a_d  = cfg_wdata[CTRL_MASK_LSB +: LANES];
          mask_b_d  = cfg_wdata[CTRL_MASK_LSB + LANES +: LANES];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a  <= '0;
      addr_b  <= '0;
      val_a   <= '0;
      val_b   <= '0;
      type_en <= '0;
      mode    <= MODE_EXACT;
      mask_a  <= '0;
      mask_b  <= '0;
    end else if (cfg_we) begin
      addr_a  <= addr_a_d;
      addr_b  <= addr_b_d;
      val_a   <= val_a_d;
      val_b   <= val_b_d;
      type_en <= type_en_d;
      mode    <= mode_d;
      mask_a  <= mask_a_d;
      mask_b  <= mask_b_d;
    end
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(addr_a) && $stable(addr_b) && $stable(val_a) &&
                 $stable(val_b) && $stable(type_en) && $stable(mask_a) && $stable(mask_b)));
endmodule

// File: rtl/watch_addr_match.sv
module watch_addr_match
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  watch_mode_e       mode,
  input  logic [3:0]        type_en,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        hit
);
  logic ok_a, ok_b;
  logic in_window;

  always_comb begin
    ok_a      = acc_valid && (acc_write ? type_en[1] : type_en[0]);
    ok_b      = acc_valid && (acc_write ? type_en[3] : type_en[2]);
    in_window = (acc_addr >= addr_a) && (acc_addr < addr_b);
    case (mode)
      MODE_INSIDE:  hit = {1'b0, ok_a && in_window};
      MODE_OUTSIDE: hit = {1'b0, ok_a && !in_window};
      default:      hit = {ok_b && (acc_addr == addr_b), ok_a && (acc_addr == addr_a)};
    endcase
  end

  // R10
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != 2'b00) |-> acc_valid);
  // R4
  window_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INSIDE || mode == MODE_OUTSIDE) |-> !hit[1]);
  // R3
  store_gate_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && acc_write) |-> type_en[1]);
  // R3
  load_gate_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && !acc_write) |-> type_en[2]);
endmodule

// File: rtl/watch_lane_match.sv
module watch_lane_match #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ref_val,
  input  logic [LANES-1:0]  mask,
  input  logic [LANES-1:0]  touched,
  input  logic [DATA_W-1:0] acc_data,
  output logic              match
);
  logic [LANES-1:0] lane_eq;
  logic [LANES-1:0] active;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_eq[l] = (acc_data[8*l +: 8] == ref_val[8*l +: 8]);
  end

  always_comb begin
    active = mask & touched;
    match  = (active != '0) && ((lane_eq & active) == active);
  end

  // R8
  match_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (mask != '0));
  // R7
  match_needs_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> ((mask & touched) != '0));
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES),
  localparam int SZ_W = $clog2(LANE_AW + 1),
  localparam int CFG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [SZ_W-1:0]   acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic [1:0]        addr_hit,
  output logic [1:0]        value_hit,
  output logic              watch_event
);
  logic rst_meta, rst_sync_n;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [DATA_W-1:0] val_a, val_b;
  logic [3:0]        type_en;
  watch_mode_e       mode;
  logic [LANES-1:0]  mask_a, mask_b;
  logic [LANES-1:0]  touched;
  logic [1:0]        lane_ok;
  logic [1:0]        qual_off;
  logic              window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  watch_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_a(addr_a), .addr_b(addr_b), .val_a(val_a),
    .val_b(val_b), .type_en(type_en), .mode(mode), .mask_a(mask_a), .mask_b(mask_b)
  );

  watch_addr_match #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .type_en(type_en),
    .addr_a(addr_a), .addr_b(addr_b), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .hit(addr_hit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_touch
    assign touched[l] = ((LANE_AW'(l) >> acc_size) == (acc_addr[LANE_AW-1:0] >> acc_size));
  end

  for (genvar v = 0; v < 2; v++) begin : g_val
    watch_lane_match #(.DATA_W(DATA_W)) lane_i (
      .clk(clk), .rst_n(rst_sync_n),
      .ref_val(v == 0 ? val_a : val_b),
      .mask(v == 0 ? mask_a : mask_b),
      .touched(touched), .acc_data(acc_data), .match(lane_ok[v])
    );
  end

  always_comb begin
    window   = (mode == MODE_INSIDE) || (mode == MODE_OUTSIDE);
    qual_off = {mask_b == '0, mask_a == '0};
    if (window) begin
      value_hit   = {2{addr_hit[0]}} & lane_ok;
      watch_event = addr_hit[0] && ((&qual_off) || (|value_hit));
    end else begin
      value_hit   = addr_hit & lane_ok;
      watch_event = |(addr_hit & (qual_off | value_hit));
    end
  end

  // R6
  value_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (value_hit != 2'b00) |-> (addr_hit != 2'b00));
  // R8
  event_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    watch_event |-> (addr_hit != 2'b00));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> (!watch_event && value_hit == 2'b00));
endmodule

// File: tb/data_watch_unit_tb_top.sv
module data_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_size;
  logic [31:0] acc_addr, acc_data;
  logic [1:0]  addr_hit, value_hit;
  logic        watch_event;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  // bench copy of programmed state
  logic [31:0] m_a, m_b, m_va, m_vb;
  logic [3:0]  m_en;
  logic [1:0]  m_mode;
  logic [3:0]  m_ma, m_mb;

  always #10 clk = ~clk;

  data_watch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_data(acc_data),
    .addr_hit(addr_hit), .value_hit(value_hit), .watch_event(watch_event)
  );

  function automatic logic vmatch(logic [31:0] refv, logic [3:0] mask,
                                  logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    logic [3:0] act;
    logic ok;
    for (int l = 0; l < 4; l++) begin
      logic t;
      if (sz == 2'd0)      t = (l == int'(a[1:0]));
      else if (sz == 2'd1) t = ((l / 2) == int'(a[1]));
      else                 t = 1'b1;
      act[l] = t & mask[l];
    end
    ok = (act != 4'b0);
    for (int l = 0; l < 4; l++)
      if (act[l] && d[8*l +: 8] != refv[8*l +: 8]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [4:0] model(logic v, logic wr, logic [1:0] sz,
                                       logic [31:0] a, logic [31:0] d);
    logic okA, okB, ev;
    logic [1:0] ah, vh;
    okA = v && (wr ? m_en[1] : m_en[0]);
    okB = v && (wr ? m_en[3] : m_en[2]);
    vh = 2'b00;
    if (m_mode == 2'b01 || m_mode == 2'b10) begin
      logic inw;
      inw = (a >= m_a) && (a < m_b);
      ah = {1'b0, okA && (m_mode == 2'b01 ? inw : !inw)};
      if (ah[0]) vh = {vmatch(m_vb, m_mb, sz, a, d), vmatch(m_va, m_ma, sz, a, d)};
      ev = ah[0] && ((m_ma == 0 && m_mb == 0) || vh != 0);
    end else begin
      ah = {okB && a == m_b, okA && a == m_a};
      vh[0] = ah[0] && vmatch(m_va, m_ma, sz, a, d);
      vh[1] = ah[1] && vmatch(m_vb, m_mb, sz, a, d);
      ev = (ah[0] && (m_ma == 0 || vh[0])) || (ah[1] && (m_mb == 0 || vh[1]));
    end
    return {ev, vh, ah};
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    case (sel)
      3'd0: m_a = d;
      3'd1: m_b = d;
      3'd2: m_va = d;
      3'd3: m_vb = d;
      3'd4: begin m_en = d[3:0]; m_mode = d[5:4]; m_ma = d[11:8]; m_mb = d[15:12]; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string tag, input logic v, input logic wr,
                        input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_size = sz; acc_addr = a; acc_data = d;
    exp_q.push_back(model(v, wr, sz, a, d));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(logic [3:0] en, logic [1:0] md,
                                       logic [3:0] ma, logic [3:0] mb);
    return {mb, ma, 2'b00, md, en};
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e, got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {watch_event, value_hit, addr_hit};
        n_checks++;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: got ev/vh/ah=%b expected %b", t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_a = 0; m_b = 0; m_va = 0; m_vb = 0; m_en = 0; m_mode = 0; m_ma = 0; m_mb = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_size = '0; acc_addr = '0; acc_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state: nothing hits
    access("R1 load addr 0", 1, 0, 2, 32'h0, 32'h0);
    access("R1 store addr 0", 1, 1, 2, 32'h0, 32'h0);

    // R11 R2 exact points
    cfg_write(3'd0, 32'h0000_1000);
    cfg_write(3'd1, 32'h0000_2004);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b00, 4'h0, 4'h0)));
    access("R2 R8 load at A", 1, 0, 2, 32'h1000, 32'h0);
    access("R2 store at B", 1, 1, 2, 32'h2004, 32'h0);
    access("R2 miss", 1, 0, 2, 32'h1004, 32'h0);
    access("R10 valid low", 0, 0, 2, 32'h1000, 32'h0);
    cfg_write(3'd6, 32'h0000_1004);   // R11 unused select
    access("R11 unused select ignored", 1, 0, 2, 32'h1000, 32'h0);

    // R3 type gating
    cfg_write(3'd4, 32'(ctrl(4'b1001, 2'b00, 4'h0, 4'h0)));
    access("R3 store at A blocked", 1, 1, 2, 32'h1000, 32'h0);
    access("R3 load at A allowed", 1, 0, 2, 32'h1000, 32'h0);
    access("R3 load at B blocked", 1, 0, 2, 32'h2004, 32'h0);
    access("R3 store at B allowed", 1, 1, 2, 32'h2004, 32'h0);

    // R4 inclusive window
    cfg_write(3'd1, 32'h0000_2000);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b01, 4'h0, 4'h0)));
    access("R4 low bound", 1, 0, 2, 32'h1000, 32'h0);
    access("R4 just below high", 1, 1, 0, 32'h1FFF, 32'h0);
    access("R4 high bound", 1, 0, 2, 32'h2000, 32'h0);
    access("R4 below low", 1, 0, 0, 32'h0FFF, 32'h0);

    // R5 exclusive window
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b10, 4'h0, 4'h0)));
    access("R5 below low", 1, 0, 0, 32'h0FFF, 32'h0);
    access("R5 high bound", 1, 0, 2, 32'h2000, 32'h0);
    access("R5 low bound", 1, 0, 2, 32'h1000, 32'h0);

    // R6 data qualification, exact mode
    cfg_write(3'd2, 32'hAABB_CCDD);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b00, 4'hF, 4'h0)));
    access("R6 word value match", 1, 0, 2, 32'h1000, 32'hAABB_CCDD);
    access("R6 word value mismatch", 1, 0, 2, 32'h1000, 32'hAABB_CCDE);
    access("R6 value without address", 1, 0, 2, 32'h1008, 32'hAABB_CCDD);

    // R7 lane selection, inclusive window
    cfg_write(3'd2, 32'h1122_3344);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b01, 4'b0010, 4'h0)));
    access("R7 byte on masked lane", 1, 0, 0, 32'h1001, 32'h0000_3300);
    access("R7 byte off mask", 1, 0, 0, 32'h1002, 32'h0000_3300);
    access("R7 half lane1 ok lane0 differs", 1, 1, 1, 32'h1000, 32'h0000_33FF);
    access("R7 half upper no overlap", 1, 1, 1, 32'h1002, 32'h1122_0000);

    // R9 either register qualifies in window mode
    cfg_write(3'd3, 32'h5566_7788);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b01, 4'b0010, 4'hF)));
    access("R9 only B matches", 1, 0, 2, 32'h1800, 32'h5566_7788);
    access("R9 only A matches", 1, 0, 2, 32'h1800, 32'h0000_3300);
    access("R9 neither matches", 1, 0, 2, 32'h1800, 32'h0);

    // R8 zero mask on B, nonzero on A, exact mode
    cfg_write(3'd1, 32'h0000_3000);
    cfg_write(3'd4, 32'(ctrl(4'hF, 2'b00, 4'hF, 4'h0)));
    access("R8 B unqualified", 1, 0, 2, 32'h3000, 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule